// File: doc/BRIEF.md
# Pipelined Two-Cycle Memory Port

This block sits between a microcoded datapath and main memory. It holds four registers that the datapath sees: a word address register, a word data register, a program counter and a one-byte instruction buffer. The address, data and program counter registers are loaded from the datapath's result bus. On each cycle the datapath may raise a word-read strobe, a word-write strobe and an instruction-fetch strobe, in any combination.

Word accesses turn the word address into a byte address by multiplying it by four. The program counter is already a byte address and is used as it is. Reads and fetches have a fixed latency. A request made in cycle k drives the memory during cycle k+1. The result lands in its register at the end of k+1 and can be used from k+2 onward. Until then the destination keeps its old value.

A request can be issued every cycle, so two requests in a row finish in two cycles in a row. The word path and the byte path have separate pipeline stages, so a read and a fetch can be in flight together. A write goes to memory in the same cycle as its strobe. It carries the data register's current contents and the scaled current address.

Top module: `pipe_mem_port`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the word address, word data, program counter and fetched byte all read zero. The read, write and fetch enables toward memory are all low.
- R2: When `addr_ld` is high at a clock edge, the word address register takes the low bits of `c_bus` at that edge.
- R3: A read strobed in cycle k raises `mem_rd_en` in cycle k+1 with `mem_rd_addr` equal to the word address held in cycle k shifted left by two. `word_data` shows the returned word from cycle k+2.
- R4: In cycle k+1 after a read strobe, `word_data` still holds the value it had in cycle k, unless that cycle also completes an earlier read or loads from `c_bus`.
- R5: Reads strobed in consecutive cycles k and k+1 deliver their words in cycles k+2 and k+3, each from the address held at its own strobe.
- R6: In a cycle with `wr_req` high, `mem_wr_en` is high. `mem_wr_addr` is the held word address shifted left by two, and `mem_wr_data` is the held data register value. A later read of that address returns the written word.
- R7: A fetch strobed in cycle k raises `mem_fetch_en` in cycle k+1 with `mem_fetch_addr` equal to the program counter held in cycle k, unscaled. `fetch_byte` shows the returned byte from cycle k+2. Fetches may be strobed in consecutive cycles.
- R8: A read and a fetch strobed in the same cycle both reach memory in the next cycle, and each delivers its own result in cycle k+2.
- R9: When a read result returns in the same cycle that `data_ld` is high, the data register takes the memory word and not `c_bus`.
- R10: When `data_ld` is high and no read is returning, the data register takes `c_bus` at that edge. Likewise `pc_ld` loads the program counter from `c_bus`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| c_bus | input | DATA_W | Datapath result bus |
| addr_ld | input | 1 | Load word address register from `c_bus` |
| data_ld | input | 1 | Load word data register from `c_bus` |
| pc_ld | input | 1 | Load program counter from `c_bus` |
| rd_req | input | 1 | Word read strobe |
| wr_req | input | 1 | Word write strobe |
| fetch_req | input | 1 | Instruction byte fetch strobe |
| word_addr | output | ADDR_W | Word address register |
| word_data | output | DATA_W | Word data register |
| pc | output | ADDR_W | Program counter (byte address) |
| fetch_byte | output | BYTE_W | Instruction byte buffer |
| mem_rd_en | output | 1 | Read access to memory this cycle |
| mem_rd_addr | output | ADDR_W | Byte address of the read |
| mem_rd_data | input | DATA_W | Word returned by memory during the read cycle |
| mem_wr_en | output | 1 | Write access to memory this cycle |
| mem_wr_addr | output | ADDR_W | Byte address of the write |
| mem_wr_data | output | DATA_W | Word to write |
| mem_fetch_en | output | 1 | Fetch access to memory this cycle |
| mem_fetch_addr | output | ADDR_W | Byte address of the fetch |
| mem_fetch_data | input | BYTE_W | Byte returned by memory during the fetch cycle |

## Verification
Some timing properties are checked on every cycle. A read or fetch strobe always produces a memory access one cycle later, at the correctly scaled or unscaled address. A cycle with no strobe produces no access. A returning word or byte is always the next value of its register, whether or not `data_ld` is high. The data register is stable in the cycle between a strobe and its result. Register loads from `c_bus` are checked the same way.

Other behaviour can only be shown by the bench's scenarios. These include the actual words and bytes seen at cycle k+2 across every address and byte lane, and the ordering of back-to-back results. They also include writes followed by read-back, and a read and a fetch running together, because each of these needs a model of the memory contents.

// File: rtl/mp_pkg.sv
package mp_pkg;
    localparam int MP_DATA_W = 32;
    localparam int MP_ADDR_W = 32;
    localparam int MP_BYTE_W = 8;

    // Number of address bits spanned by one word: log2(bytes per word)
    function automatic int mp_word_shift(input int data_w, input int byte_w);
        return $clog2(data_w / byte_w);
    endfunction
endpackage

// File: rtl/mp_scale.sv
module mp_scale #(
    parameter int W     = 32,
    parameter int SHIFT = 2
) (
    input  logic [W-1:0] word_addr_i,
    output logic [W-1:0] byte_addr_o
);
    generate
        if (SHIFT == 0) begin : g_pass
            assign byte_addr_o = word_addr_i;
        end else begin : g_shift
            assign byte_addr_o = {word_addr_i[W-1-SHIFT:0], {SHIFT{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/mp_word_path.sv
module mp_word_path #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int SHIFT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] c_bus,
    input  logic              addr_ld,
    input  logic              data_ld,
    input  logic              rd_req,
    input  logic              wr_req,
    output logic [ADDR_W-1:0] word_addr,
    output logic [DATA_W-1:0] word_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              pend;
        logic [ADDR_W-1:0] pend_addr;
    } wstate_t;

    wstate_t           st_d, st_q;
    logic [ADDR_W-1:0] scaled;

    mp_scale #(.W(ADDR_W), .SHIFT(SHIFT)) u_scale (
        .word_addr_i (st_q.addr),
        .byte_addr_o (scaled)
    );

    always_comb begin
        st_d = st_q;
        if (addr_ld) st_d.addr = c_bus[ADDR_W-1:0];
        if (data_ld) st_d.data = c_bus;
        // A returning read wins over a bus load in the same cycle
        if (st_q.pend) st_d.data = mem_rd_data;
        st_d.pend      = rd_req;
        st_d.pend_addr = scaled;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_addr   = st_q.addr;
    assign word_data   = st_q.data;
    assign mem_rd_en   = st_q.pend;
    assign mem_rd_addr = st_q.pend_addr;
    assign mem_wr_en   = wr_req;
    assign mem_wr_addr = scaled;
    assign mem_wr_data = st_q.data;
endmodule

// File: rtl/mp_byte_path.sv
module mp_byte_path #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] c_bus,
    input  logic              pc_ld,
    input  logic              fetch_req,
    output logic [ADDR_W-1:0] pc,
    output logic [BYTE_W-1:0] fetch_byte,
    output logic              mem_fetch_en,
    output logic [ADDR_W-1:0] mem_fetch_addr,
    input  logic [BYTE_W-1:0] mem_fetch_data
);
    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [BYTE_W-1:0] buf_byte;
        logic              pend;
        logic [ADDR_W-1:0] pend_addr;
    } bstate_t;

    bstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pc_ld)     st_d.pc       = c_bus[ADDR_W-1:0];
        if (st_q.pend) st_d.buf_byte = mem_fetch_data;
        st_d.pend      = fetch_req;
        st_d.pend_addr = st_q.pc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc             = st_q.pc;
    assign fetch_byte     = st_q.buf_byte;
    assign mem_fetch_en   = st_q.pend;
    assign mem_fetch_addr = st_q.pend_addr;
endmodule

// File: rtl/pipe_mem_port.sv
module pipe_mem_port #(
    parameter int DATA_W = mp_pkg::MP_DATA_W,
    parameter int ADDR_W = mp_pkg::MP_ADDR_W,
    parameter int BYTE_W = mp_pkg::MP_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] c_bus,
    input  logic              addr_ld,
    input  logic              data_ld,
    input  logic              pc_ld,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              fetch_req,
    output logic [ADDR_W-1:0] word_addr,
    output logic [DATA_W-1:0] word_data,
    output logic [ADDR_W-1:0] pc,
    output logic [BYTE_W-1:0] fetch_byte,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              mem_fetch_en,
    output logic [ADDR_W-1:0] mem_fetch_addr,
    input  logic [BYTE_W-1:0] mem_fetch_data
);
    localparam int WORD_SHIFT = mp_pkg::mp_word_shift(DATA_W, BYTE_W);

    mp_word_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SHIFT(WORD_SHIFT)) u_word (
        .clk         (clk),
        .rst_n       (rst_n),
        .c_bus       (c_bus),
        .addr_ld     (addr_ld),
        .data_ld     (data_ld),
        .rd_req      (rd_req),
        .wr_req      (wr_req),
        .word_addr   (word_addr),
        .word_data   (word_data),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data)
    );

    mp_byte_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_byte (
        .clk            (clk),
        .rst_n          (rst_n),
        .c_bus          (c_bus),
        .pc_ld          (pc_ld),
        .fetch_req      (fetch_req),
        .pc             (pc),
        .fetch_byte     (fetch_byte),
        .mem_fetch_en   (mem_fetch_en),
        .mem_fetch_addr (mem_fetch_addr),
        .mem_fetch_data (mem_fetch_data)
    );
endmodule

// File: rtl/pipe_mem_port_chk.sv
module pipe_mem_port_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] c_bus,
    input logic              addr_ld,
    input logic              data_ld,
    input logic              pc_ld,
    input logic              rd_req,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] word_addr,
    input logic [DATA_W-1:0] word_data,
    input logic [ADDR_W-1:0] pc,
    input logic [BYTE_W-1:0] fetch_byte,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic [DATA_W-1:0] mem_rd_data,
    input logic              mem_fetch_en,
    input logic [ADDR_W-1:0] mem_fetch_addr,
    input logic [BYTE_W-1:0] mem_fetch_data
);
    localparam int SH = mp_pkg::mp_word_shift(DATA_W, BYTE_W);

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ld |=> word_addr == $past(c_bus[ADDR_W-1:0])); // R2

    AST_RD_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> mem_rd_en && (mem_rd_addr == ($past(word_addr) << SH))); // R3

    AST_RD_LAND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> word_data == $past(mem_rd_data)); // R9

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !mem_rd_en && !data_ld) |=> $stable(word_data)); // R4

    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !mem_rd_en); // R5

    AST_FETCH_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> mem_fetch_en && (mem_fetch_addr == $past(pc))); // R7

    AST_FETCH_LAND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_fetch_en |=> fetch_byte == $past(mem_fetch_data)); // R7

    AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        pc_ld |=> pc == $past(c_bus[ADDR_W-1:0])); // R10
endmodule

bind pipe_mem_port pipe_mem_port_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .c_bus(c_bus), .addr_ld(addr_ld),
    .data_ld(data_ld), .pc_ld(pc_ld), .rd_req(rd_req), .fetch_req(fetch_req),
    .word_addr(word_addr), .word_data(word_data), .pc(pc),
    .fetch_byte(fetch_byte), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_fetch_en(mem_fetch_en),
    .mem_fetch_addr(mem_fetch_addr), .mem_fetch_data(mem_fetch_data)
);

// File: tb/pipe_mem_port_tb.sv
`timescale 1ns/1ps
module pipe_mem_port_tb;
    localparam int DW = 32;
    localparam int AW = 32;
    localparam int BW = 8;
    localparam int NW = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [DW-1:0] c_bus = '0;
    logic          addr_ld = 0, data_ld = 0, pc_ld = 0;
    logic          rd_req = 0, wr_req = 0, fetch_req = 0;
    logic [AW-1:0] word_addr, pc, mem_rd_addr, mem_wr_addr, mem_fetch_addr;
    logic [DW-1:0] word_data, mem_rd_data, mem_wr_data;
    logic [BW-1:0] fetch_byte, mem_fetch_data;
    logic          mem_rd_en, mem_wr_en, mem_fetch_en;

    pipe_mem_port u_dut (
        .clk(clk), .rst_n(rst_n), .c_bus(c_bus), .addr_ld(addr_ld),
        .data_ld(data_ld), .pc_ld(pc_ld), .rd_req(rd_req), .wr_req(wr_req),
        .fetch_req(fetch_req), .word_addr(word_addr), .word_data(word_data),
        .pc(pc), .fetch_byte(fetch_byte), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_fetch_en(mem_fetch_en),
        .mem_fetch_addr(mem_fetch_addr), .mem_fetch_data(mem_fetch_data)
    );

    function automatic logic [DW-1:0] word0(input int i);
        return 32'hA050_3010 + i * 32'h0101_0101;
    endfunction

    function automatic logic [BW-1:0] byte0(input int p);
        logic [DW-1:0] w;
        w = word0(p / 4) >> (8 * (p % 4));
        return w[BW-1:0];
    endfunction

    // Behavioural memory: word array, combinational read, write at the edge
    logic [DW-1:0] mem [NW];
    logic [DW-1:0] fword;
    assign mem_rd_data    = mem[mem_rd_addr[5:2]];
    assign fword          = mem[mem_fetch_addr[5:2]];
    assign mem_fetch_data = fword[8*mem_fetch_addr[1:0] +: 8];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) mem[i] <= word0(i);
        end else if (mem_wr_en) begin
            mem[mem_wr_addr[5:2]] <= mem_wr_data;
        end
    end

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    logic [DW-1:0] shadow [NW];
    logic [DW-1:0] prev;

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    endtask

    task automatic check_reset_state(input string tag);
        chk({tag, " word_addr"}, word_addr, '0);
        chk({tag, " word_data"}, word_data, '0);
        chk({tag, " pc"}, pc, '0);
        chk({tag, " fetch_byte"}, {24'h0, fetch_byte}, '0);
        chk({tag, " rd_en"}, {31'h0, mem_rd_en}, '0);
        chk({tag, " wr_en"}, {31'h0, mem_wr_en}, '0);
        chk({tag, " fetch_en"}, {31'h0, mem_fetch_en}, '0);
    endtask

    // Single read of word i, checking issue, hold and arrival
    task automatic single_read(input int i, input logic [DW-1:0] expw);
        c_bus = i; addr_ld = 1; cyc();
        addr_ld = 0;
        chk("R2 addr load", word_addr, i);
        rd_req = 1; cyc();
        rd_req = 0;
        chk("R3 rd_en", {31'h0, mem_rd_en}, 1);
        chk("R3 rd_addr scaled", mem_rd_addr, i * 4);
        chk("R4 data held", word_data, prev);
        cyc();
        chk("R3 data at k+2", word_data, expw);
        prev = expw;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        prev = '0;
        for (int i = 0; i < NW; i++) shadow[i] = word0(i);
        repeat (3) cyc();
        check_reset_state("R1 in reset");
        rst_n = 1; cyc();
        check_reset_state("R1 after release");

        // Single reads across all words
        for (int i = 0; i < NW; i++) single_read(i, word0(i));

        // Back-to-back reads: R5
        for (int i = 0; i < 8; i++) begin
            c_bus = i; addr_ld = 1; cyc();
            rd_req = 1; c_bus = 15 - i; cyc();
            addr_ld = 0; cyc();
            rd_req = 0;
            chk("R5 first k+2", word_data, word0(i));
            cyc();
            chk("R5 second k+3", word_data, word0(15 - i));
            prev = word0(15 - i);
        end

        // Fetch sweep over every byte lane: R7
        c_bus = 0; pc_ld = 1; cyc();
        for (int j = 0; j < 4 * NW; j++) begin
            fetch_req = 1; pc_ld = 1; c_bus = j + 1; cyc();
            if (j >= 1) begin
                chk("R7 fetch addr", mem_fetch_addr, j);
                chk("R7 fetch byte", {24'h0, fetch_byte}, {24'h0, byte0(j - 1)});
            end
        end
        fetch_req = 0; pc_ld = 0; cyc();
        chk("R7 last byte", {24'h0, fetch_byte}, {24'h0, byte0(4 * NW - 1)});
        chk("R10 pc load", pc, 4 * NW);

        // Concurrent read and fetch: R8
        for (int i = 0; i < 8; i++) begin
            c_bus = i; addr_ld = 1; cyc();
            addr_ld = 0; c_bus = 4 * (15 - i) + (i % 4); pc_ld = 1; cyc();
            pc_ld = 0; rd_req = 1; fetch_req = 1; cyc();
            rd_req = 0; fetch_req = 0;
            chk("R8 rd_en", {31'h0, mem_rd_en}, 1);
            chk("R8 fetch_en", {31'h0, mem_fetch_en}, 1);
            cyc();
            chk("R8 word", word_data, word0(i));
            chk("R8 byte", {24'h0, fetch_byte}, {24'h0, byte0(4 * (15 - i) + (i % 4))});
            prev = word0(i);
        end

        // Writes: R6, with data loads R10
        for (int i = 0; i < NW; i++) begin
            logic [DW-1:0] v;
            v = ~word0(i) ^ (i * 32'h0001_0003);
            c_bus = i; addr_ld = 1; cyc();
            addr_ld = 0; c_bus = v; data_ld = 1; cyc();
            data_ld = 0;
            chk("R10 data load", word_data, v);
            wr_req = 1; #1;
            chk("R6 wr_en", {31'h0, mem_wr_en}, 1);
            chk("R6 wr_addr", mem_wr_addr, i * 4);
            chk("R6 wr_data", mem_wr_data, v);
            cyc();
            wr_req = 0;
            shadow[i] = v;
            prev = v;
        end
        for (int i = 0; i < NW; i++) single_read(i, shadow[i]);

        // Returning read beats a bus load: R9
        c_bus = 3; addr_ld = 1; cyc();
        addr_ld = 0; rd_req = 1; cyc();
        rd_req = 0; data_ld = 1; c_bus = 32'hDEAD_BEEF; cyc();
        data_ld = 0;
        chk("R9 memory wins", word_data, shadow[3]);
        cyc();
        chk("R9 held after", word_data, shadow[3]);
        data_ld = 1; c_bus = 32'h1234_5678; cyc();
        data_ld = 0;
        chk("R10 plain load", word_data, 32'h1234_5678);

        // Reset again mid-run
        rst_n = 0; cyc();
        check_reset_state("R1 re-reset");
        rst_n = 1; cyc();

        finish_run();
    end
endmodule